// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Context Flush

This block holds a small set of recent virtual-to-physical page translations and answers lookups in the same cycle. A lookup presents a 32-bit virtual address. On a hit the block returns the physical address, built from the stored 20-bit frame number and the untranslated 12-bit byte offset of a 4 KB page, together with the permission and status flags kept with that translation.

New translations are written through a fill port. The fill uses the first free slot if there is one, or a round-robin victim when all slots are occupied. A fill for a page that is already present rewrites that slot in place. Two maintenance inputs keep the contents coherent with the page tables. A context-switch flush drops every translation that is not marked global. A single-page invalidate drops the translation of one page after that page has been moved out or its table entry has changed.

Top module: `tlb_cache`

## Requirements
- R1: After reset every slot is empty, every lookup misses, and the round-robin pointer is at slot 0.
- R2: Lookup is combinational. `lk_hit` is 1 in the same cycle as the address only when a valid slot's page tag equals `lk_vaddr[31:12]`. On a hit, `lk_paddr` is `{frame, lk_vaddr[11:0]}`.
- R3: A fill in one cycle is visible to lookups from the next cycle onward.
- R4: A fill whose page tag matches a valid slot rewrites that slot's frame and flags. No second copy is made and no other slot changes.
- R5: A fill for a new page goes to the lowest-numbered empty slot when one exists.
- R6: When all 16 slots are valid, a fill for a new page replaces the slot named by a round-robin pointer. The pointer then advances by one, modulo 16. Only such replacements move the pointer.
- R7: `flush_ctx` empties every slot whose global flag is 0.
- R8: Slots whose global flag is 1 are unchanged by `flush_ctx`.
- R9: `inval_en` empties the slot whose tag equals `inval_vpn`.
- R10: An invalidate whose page is not present leaves every translation and the pointer unchanged.
- R11: When several operations arrive in the same cycle, the flush is applied first, then the invalidate, then the fill. The fill's slot choice is made on the contents left after the flush and the invalidate, so the filled page is present afterwards.
- R12: Flag field layout on `fill_flags` and `lk_flags` is bit 3 global, bit 2 writable, bit 1 dirty, bit 0 accessed. The bits are returned exactly as they were filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation present |
| lk_paddr | output | 32 | Physical address (frame and offset) |
| lk_flags | output | 4 | Flags of the hit slot |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number to fill |
| fill_pfn | input | 20 | Physical frame number to fill |
| fill_flags | input | 4 | Flags to fill |
| flush_ctx | input | 1 | Drop all non-global translations |
| inval_en | input | 1 | Drop one page's translation |
| inval_vpn | input | 20 | Page number to drop |

## Verification
A corrupted valid bit or tag shows up on the very next lookup of that page, as a spurious hit or miss. A corrupted frame shows up as a wrong `lk_paddr`. A wrong slot choice or a round-robin pointer that drifts shows no symptom until the cache is full and a replacement happens. At that point the wrong resident page vanishes, so the bench fills past capacity several times and sweeps every page it has used after each step. A flush or invalidate that keeps an entry it should drop surfaces on the first lookup of that page after the operation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic glob;
    logic wr;
    logic dirty;
    logic acc;
  } tlb_flags_t;
  localparam int FLAGS_W = $bits(tlb_flags_t);
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N     = 16,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]     vld,
  input  logic [TAG_W-1:0] tags [N],
  input  logic [TAG_W-1:0] key,
  output logic [N-1:0]     hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tags[i] == key);
  end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     same_tag,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] slot,
  output logic             evict
);
  always_comb begin
    slot  = rr_ptr;
    evict = 1'b1;
    // scan downward so the lowest empty slot wins
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        slot  = IDX_W'(i);
        evict = 1'b0;
      end
    end
    // an existing copy of the page always takes priority
    for (int i = 0; i < N; i++) begin
      if (same_tag[i]) begin
        slot  = IDX_W'(i);
        evict = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
  output logic                     lk_hit,
  output logic [PFN_W+OFF_W-1:0]   lk_paddr,
  output logic [3:0]               lk_flags,
  input  logic                     fill_en,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PFN_W-1:0]         fill_pfn,
  input  logic [3:0]               fill_flags,
  input  logic                     flush_ctx,
  input  logic                     inval_en,
  input  logic [VPN_W-1:0]         inval_vpn
);
  import tlb_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VA_W  = VPN_W + OFF_W;

  logic [VPN_W-1:0]   ent_tag [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn [ENTRIES];
  tlb_flags_t         ent_flg [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] glob_vec, lk_match, inv_match, fill_match;
  logic [ENTRIES-1:0] valid_clr, valid_nxt;
  logic [IDX_W-1:0]   fill_slot;
  logic               fill_evict;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_glob
    assign glob_vec[i] = ent_flg[i].glob;
  end

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
    .vld(valid), .tags(ent_tag), .key(lk_vaddr[VA_W-1:OFF_W]), .hit_vec(lk_match));

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_inv_cam (
    .vld(valid), .tags(ent_tag), .key(inval_vpn), .hit_vec(inv_match));

  // flush first, then single-page invalidate
  always_comb begin
    valid_clr = valid;
    if (flush_ctx) valid_clr = valid_clr & glob_vec;
    if (inval_en)  valid_clr = valid_clr & ~inv_match;
  end

  tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill_cam (
    .vld(valid_clr), .tags(ent_tag), .key(fill_vpn), .hit_vec(fill_match));

  tlb_slot_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .vld(valid_clr), .same_tag(fill_match), .rr_ptr(rr_ptr),
    .slot(fill_slot), .evict(fill_evict));

  always_comb begin
    valid_nxt = valid_clr;
    if (fill_en) valid_nxt[fill_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= '0;
      rr_ptr <= '0;
    end else begin
      valid <= valid_nxt;
      if (fill_en && fill_evict) begin
        if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
        else                               rr_ptr <= rr_ptr + 1'b1;
      end
    end
  end

  // storage arrays carry no reset; validity is tracked separately
  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_tag[fill_slot] <= fill_vpn;
      ent_pfn[fill_slot] <= fill_pfn;
      ent_flg[fill_slot] <= tlb_flags_t'(fill_flags);
    end
  end

  logic [PFN_W-1:0] sel_pfn;
  tlb_flags_t       sel_flg;
  always_comb begin
    sel_pfn = '0;
    sel_flg = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_pfn = sel_pfn | ent_pfn[i];
        sel_flg = sel_flg | ent_flg[i];
      end
    end
  end

  assign lk_hit   = |lk_match;
  assign lk_paddr = {sel_pfn, lk_vaddr[OFF_W-1:0]};
  assign lk_flags = sel_flg;
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   lk_hit,
  input logic [3:0]             lk_flags,
  input logic                   fill_en,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic                   flush_ctx,
  input logic                   inval_en,
  input logic [VPN_W-1:0]       inval_vpn,
  input logic [ENTRIES-1:0]     lk_match
);
  localparam int VA_W = VPN_W + OFF_W;

  // R1
  reset_empty_chk: assert property (@(posedge clk) $past(rst) |-> !lk_hit);

  // R3
  fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_en) && !$past(rst) && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> lk_hit);

  // R4
  single_copy_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(lk_match));

  // R7
  flush_leaves_glob_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flush_ctx && !fill_en) && !$past(rst) && lk_hit) |-> lk_flags[3]);

  // R9
  inval_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(inval_en && !fill_en) && !$past(rst) && lk_vaddr[VA_W-1:OFF_W] == $past(inval_vpn))
      |-> !lk_hit);
endmodule

bind tlb_cache tlb_cache_chk #(.VPN_W(VPN_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_flags(lk_flags),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .flush_ctx(flush_ctx),
  .inval_en(inval_en), .inval_vpn(inval_vpn), .lk_match(lk_match));

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_flags;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [3:0]  fill_flags = '0;
  logic        flush_ctx = 1'b0;
  logic        inval_en = 1'b0;
  logic [19:0] inval_vpn = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_cache i_tlb_cache (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_flags(lk_flags), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_flags(fill_flags), .flush_ctx(flush_ctx), .inval_en(inval_en),
    .inval_vpn(inval_vpn));

  // reference model
  bit          m_v [N];
  logic [19:0] m_t [N];
  logic [19:0] m_p [N];
  logic [3:0]  m_f [N];
  int          m_rr;

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic model_step(bit fl, bit iv, logic [19:0] ivpn, bit fe,
                            logic [19:0] fvpn, logic [19:0] fpfn, logic [3:0] fflg);
    int slot;
    if (fl) for (int i = 0; i < N; i++) if (!m_f[i][3]) m_v[i] = 1'b0;
    if (iv) for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == ivpn) m_v[i] = 1'b0;
    if (fe) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == fvpn) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1'b1; m_t[slot] = fvpn; m_p[slot] = fpfn; m_f[slot] = fflg;
    end
  endtask

  task automatic step(bit fl, bit iv, logic [19:0] ivpn, bit fe,
                      logic [19:0] fvpn, logic [19:0] fpfn, logic [3:0] fflg);
    @(negedge clk);
    flush_ctx = fl; inval_en = iv; inval_vpn = ivpn;
    fill_en = fe; fill_vpn = fvpn; fill_pfn = fpfn; fill_flags = fflg;
    @(posedge clk);
    #1;
    flush_ctx = 1'b0; inval_en = 1'b0; fill_en = 1'b0;
    model_step(fl, iv, ivpn, fe, fvpn, fpfn, fflg);
  endtask

  task automatic probe(logic [19:0] vpn, string req);
    logic [11:0] off;
    bit          e_hit;
    logic [31:0] e_pa;
    logic [3:0]  e_fl;
    off = 12'($urandom);
    lk_vaddr = {vpn, off};
    #1;
    e_hit = 1'b0; e_pa = '0; e_fl = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_t[i] == vpn) begin
        e_hit = 1'b1; e_pa = {m_p[i], off}; e_fl = m_f[i];
      end
    checks++;
    if (lk_hit !== e_hit || (e_hit && (lk_paddr !== e_pa || lk_flags !== e_fl))) begin
      fails++;
      $display("FAIL %s vpn=%h hit=%b/%b paddr=%h/%h flags=%h/%h (actual/expected)",
               req, vpn, lk_hit, e_hit, lk_paddr, e_pa, lk_flags, e_fl);
    end
  endtask

  task automatic sweep(logic [19:0] base, int cnt, string req);
    for (int k = 0; k < cnt; k++) probe(base + 20'(k), req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: empty after reset
    sweep(20'h00100, 4, "R1");

    // R2 R3 R12: basic fills with distinct flag patterns
    step(0, 0, 0, 1, 20'h00100, 20'hABCDE, 4'b0101);
    step(0, 0, 0, 1, 20'h00101, 20'h12345, 4'b1010);
    step(0, 0, 0, 1, 20'h00102, 20'hFFFFF, 4'b1111);
    sweep(20'h00100, 4, "R2_R3_R12");

    // R5: fill up to capacity using lowest free slots
    for (int i = 3; i < N; i++) step(0, 0, 0, 1, 20'h00100 + 20'(i), 20'h00A00 + 20'(i), 4'b0100);
    sweep(20'h00100, N, "R5");

    // R6: replacements follow the round-robin pointer from slot 0
    step(0, 0, 0, 1, 20'h00200, 20'h00B00, 4'b0001);
    sweep(20'h00100, 2, "R6");
    step(0, 0, 0, 1, 20'h00201, 20'h00B01, 4'b0001);
    sweep(20'h00100, 3, "R6");
    sweep(20'h00200, 2, "R6");

    // R4: rewrite in place
    step(0, 0, 0, 1, 20'h00105, 20'h55555, 4'b0110);
    sweep(20'h00100, N, "R4");
    sweep(20'h00200, 2, "R4");

    // R9 then R5: invalidate frees slot 3, next fill lands there
    step(0, 1, 20'h00103, 0, 0, 0, 0);
    probe(20'h00103, "R9");
    step(0, 0, 0, 1, 20'h00300, 20'h00C00, 4'b0000);
    step(0, 0, 0, 1, 20'h00301, 20'h00C01, 4'b0000);
    sweep(20'h00100, N, "R5_R6");
    sweep(20'h00300, 2, "R5_R6");

    // R10: invalidate of absent page changes nothing
    step(0, 1, 20'h0FFFF, 0, 0, 0, 0);
    sweep(20'h00100, N, "R10");
    sweep(20'h00200, 2, "R10");
    sweep(20'h00300, 2, "R10");

    // R7 R8: flush keeps only global slots
    step(0, 0, 0, 1, 20'h00104, 20'h00D04, 4'b1000);
    step(1, 0, 0, 0, 0, 0, 0);
    sweep(20'h00100, N, "R7_R8");
    sweep(20'h00200, 2, "R7_R8");
    sweep(20'h00300, 2, "R7_R8");

    // R11: flush + invalidate + fill in one cycle
    step(1, 1, 20'h00400, 1, 20'h00400, 20'h00E00, 4'b0011);
    probe(20'h00400, "R11");
    sweep(20'h00100, 4, "R11");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit fl, iv, fe;
      fl = ($urandom_range(0, 99) < 4);
      iv = ($urandom_range(0, 99) < 15);
      fe = ($urandom_range(0, 99) < 65);
      step(fl, iv, 20'($urandom_range(0, 39)), fe, 20'($urandom_range(0, 39)),
           20'($urandom), 4'($urandom));
      probe(20'($urandom_range(0, 39)), "R6_R11_rand");
      if (n % 50 == 0) sweep(20'h0, 40, "R4_R7_R9_rand");
    end

    // R1: reset mid-run empties everything
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    model_reset();
    sweep(20'h0, 40, "R1");

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule